// File: doc/BRIEF.md
# Bus Access Cycle Timer

This block decides how long a processor bus access lasts and then paces it. From the upper sixteen address bits (bank and page) and a fast-region enable bit, it picks one of three access lengths: 6, 8 or 12 master-clock cycles. It then runs the access as a string of ticks. Each clock of the block stands for one tick of two master cycles, so a 6-cycle access lasts three clocks, an 8-cycle access four, and a 12-cycle access six.

While an access runs, the block raises a per-tick strobe so that an outside event scheduler can advance in step. It also raises a strobe at the point where data is taken and a one-clock done strobe on the last tick. A read takes its data four master cycles (two ticks) before the end of the access. A write holds its data for the whole access and commits on the last tick.

The processor side raises `start_i` with the address and direction for one clock while the block is idle. The length is fixed at that clock, and the block ignores everything on its inputs until the access ends.

Top module: `bus_access_timer`

## Requirements
- R1: Bank numbers 0x40 to 0x7F (address bits 23:16) always give an 8-master-cycle access (4 busy clocks).
- R2: Banks 0xC0 to 0xFF give 6 master cycles (3 clocks) when `fast_en_i` is 1, and 8 master cycles (4 clocks) when it is 0.
- R3: In banks 0x00–0x3F and 0x80–0xBF, page numbers (address bits 15:8) 0x20–0x3F and 0x42–0x5F give 6 master cycles. Pages 0x00–0x1F and 0x60–0x7F give 8 master cycles.
- R4: In banks 0x00–0x3F and 0x80–0xBF, pages 0x40 and 0x41 give 12 master cycles (6 clocks).
- R5: Pages 0x80–0xFF give 8 master cycles in banks 0x00–0x3F. In banks 0x80–0xBF they give 6 master cycles when `fast_en_i` is 1 and 8 when it is 0.
- R6: A start taken at a clock edge while idle raises `busy_o` from the next clock, for exactly (master cycles / 2) clocks. `tick_o` is high on each of those clocks and low otherwise.
- R7: For a read (`write_i` = 0), `sample_o` is high for one clock: the busy clock that has exactly two busy clocks after it.
- R8: For a write (`write_i` = 1), `sample_o` is high for one clock, on the last busy clock.
- R9: `done_o` is high for exactly one clock, on the last busy clock of every access.
- R10: A start request while busy is ignored. Changes to the address, direction or fast enable during an access change neither its length nor its strobe positions.
- R11: During and right after reset, `busy_o`, `tick_o`, `sample_o` and `done_o` are 0, and a start held during reset begins no access.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_i | input | 1 | Block clock, one tick of two master cycles per period |
| rst_ni | input | 1 | Active-low synchronous reset |
| start_i | input | 1 | Access request, taken only while idle |
| write_i | input | 1 | 1 = write access, 0 = read access |
| fast_en_i | input | 1 | Enables the fast timing of the upper ROM regions |
| addr_i | input | 16 | Bank (bits 15:8) and page (bits 7:0) of the access address |
| busy_o | output | 1 | Access in progress |
| sample_o | output | 1 | Data is taken on this clock |
| done_o | output | 1 | Last clock of the access |
| tick_o | output | 1 | One strobe per two-master-cycle tick |

## Verification
A wrong length class or remaining-tick count shows up at the ports in the access it affects. `done_o` and the drop of `busy_o` then come one or more clocks early or late, and for reads `sample_o` moves too, two clocks before the end. A lost direction bit shows within the same access, because `sample_o` lands on the wrong clock. A counter reloaded by a start request during an access stretches `busy_o` past the expected end. Each of these faults is visible no later than the clock on which the correct access would have ended.

// File: rtl/bat_pkg.sv
package bat_pkg;
   typedef enum logic [1:0] {
      SPD_FAST  = 2'd0,
      SPD_SLOW  = 2'd1,
      SPD_XSLOW = 2'd2
   } bat_speed_e;
endpackage

// File: rtl/bat_speed_map.sv
module bat_speed_map
   import bat_pkg::*;
#(
   parameter int BANK_W = 8,
   parameter int PAGE_W = 8
) (
   input  logic [BANK_W-1:0] bank_i,
   input  logic [PAGE_W-1:0] page_i,
   input  logic              fast_en_i,
   output bat_speed_e        speed_o
);
   // The region boundaries below assume an 8-bit bank and an 8-bit page
   generate
      if (BANK_W != 8) begin : g_bad_bank
         $error("bat_speed_map: BANK_W must be 8");
      end
      if (PAGE_W != 8) begin : g_bad_page
         $error("bat_speed_map: PAGE_W must be 8");
      end
   endgenerate

   logic upper_half;   // bank bit 7: second copy of the map
   logic data_bank;    // bank bit 6: plain memory banks
   logic fast_hi;

   assign upper_half = bank_i[BANK_W-1];
   assign data_bank  = bank_i[BANK_W-2];
   assign fast_hi    = upper_half & fast_en_i;

   always_comb begin
      speed_o = SPD_SLOW;
      if (data_bank) begin
         speed_o = fast_hi ? SPD_FAST : SPD_SLOW;
      end else if (page_i < 8'h20) begin
         speed_o = SPD_SLOW;
      end else if (page_i < 8'h40) begin
         speed_o = SPD_FAST;
      end else if (page_i < 8'h42) begin
         speed_o = SPD_XSLOW;
      end else if (page_i < 8'h60) begin
         speed_o = SPD_FAST;
      end else if (page_i < 8'h80) begin
         speed_o = SPD_SLOW;
      end else begin
         speed_o = fast_hi ? SPD_FAST : SPD_SLOW;
      end
   end
endmodule

// File: rtl/bat_pacer.sv
module bat_pacer #(
   parameter int CNT_W      = 3,
   parameter int TAIL_TICKS = 2
) (
   input  logic             clk_i,
   input  logic             rst_ni,
   input  logic             start_i,
   input  logic             write_i,
   input  logic [CNT_W-1:0] len_i,
   output logic             busy_o,
   output logic             sample_o,
   output logic             done_o,
   output logic             tick_o
);
   localparam logic [CNT_W-1:0] LAST_LEFT   = CNT_W'(1);
   localparam logic [CNT_W-1:0] SAMPLE_LEFT = CNT_W'(TAIL_TICKS + 1);

   logic [CNT_W-1:0] left_q;
   logic             wr_q;
   logic             active;
   logic             accept;

   assign active = (left_q != '0);
   assign accept = start_i & ~active;

   always_ff @(posedge clk_i) begin
      if (!rst_ni) begin
         left_q <= '0;
         wr_q   <= 1'b0;
      end else if (accept) begin
         left_q <= len_i;
         wr_q   <= write_i;
      end else if (active) begin
         left_q <= left_q - LAST_LEFT;
      end
   end

   assign busy_o   = active;
   assign tick_o   = active;
   assign done_o   = (left_q == LAST_LEFT);
   assign sample_o = active & (wr_q ? (left_q == LAST_LEFT) : (left_q == SAMPLE_LEFT));
endmodule

// File: rtl/bus_access_timer.sv
module bus_access_timer
   import bat_pkg::*;
#(
   parameter int BANK_W        = 8,
   parameter int PAGE_W        = 8,
   parameter int MCLK_PER_TICK = 2,
   parameter int FAST_MCLK     = 6,
   parameter int SLOW_MCLK     = 8,
   parameter int XSLOW_MCLK    = 12,
   parameter int READ_TAIL     = 4,
   localparam int ADDR_W       = BANK_W + PAGE_W
) (
   input  logic              clk_i,
   input  logic              rst_ni,
   input  logic              start_i,
   input  logic              write_i,
   input  logic              fast_en_i,
   input  logic [ADDR_W-1:0] addr_i,
   output logic              busy_o,
   output logic              sample_o,
   output logic              done_o,
   output logic              tick_o
);
   localparam int FAST_TICKS  = FAST_MCLK / MCLK_PER_TICK;
   localparam int SLOW_TICKS  = SLOW_MCLK / MCLK_PER_TICK;
   localparam int XSLOW_TICKS = XSLOW_MCLK / MCLK_PER_TICK;
   localparam int TAIL_TICKS  = READ_TAIL / MCLK_PER_TICK;
   localparam int CNT_W       = $clog2(XSLOW_TICKS + 1);

   generate
      if (MCLK_PER_TICK < 1) begin : g_bad_tick
         $error("bus_access_timer: MCLK_PER_TICK must be positive");
      end
      if ((FAST_MCLK % MCLK_PER_TICK) != 0 || (SLOW_MCLK % MCLK_PER_TICK) != 0 ||
          (XSLOW_MCLK % MCLK_PER_TICK) != 0 || (READ_TAIL % MCLK_PER_TICK) != 0) begin : g_bad_div
         $error("bus_access_timer: lengths must be whole ticks");
      end
      if (TAIL_TICKS < 1 || FAST_TICKS <= TAIL_TICKS) begin : g_bad_tail
         $error("bus_access_timer: read tail must be shorter than the fastest access");
      end
      if (!(FAST_TICKS < SLOW_TICKS && SLOW_TICKS < XSLOW_TICKS)) begin : g_bad_order
         $error("bus_access_timer: speeds must be strictly ordered");
      end
   endgenerate

   bat_speed_e       speed;
   logic [CNT_W-1:0] len;

   bat_speed_map #(
      .BANK_W (BANK_W),
      .PAGE_W (PAGE_W)
   ) u_map (
      .bank_i    (addr_i[ADDR_W-1:PAGE_W]),
      .page_i    (addr_i[PAGE_W-1:0]),
      .fast_en_i (fast_en_i),
      .speed_o   (speed)
   );

   always_comb begin
      unique case (speed)
         SPD_FAST:  len = CNT_W'(FAST_TICKS);
         SPD_XSLOW: len = CNT_W'(XSLOW_TICKS);
         default:   len = CNT_W'(SLOW_TICKS);
      endcase
   end

   bat_pacer #(
      .CNT_W      (CNT_W),
      .TAIL_TICKS (TAIL_TICKS)
   ) u_pacer (
      .clk_i    (clk_i),
      .rst_ni   (rst_ni),
      .start_i  (start_i),
      .write_i  (write_i),
      .len_i    (len),
      .busy_o   (busy_o),
      .sample_o (sample_o),
      .done_o   (done_o),
      .tick_o   (tick_o)
   );
endmodule

// File: rtl/bus_access_timer_chk.sv
module bus_access_timer_chk (
   input logic clk_i,
   input logic rst_ni,
   input logic start_i,
   input logic write_i,
   input logic busy_o,
   input logic sample_o,
   input logic done_o,
   input logic tick_o
);
   logic       wr_seen;
   logic [3:0] run_len;

   always_ff @(posedge clk_i) begin
      if (!rst_ni) begin
         wr_seen <= 1'b0;
         run_len <= '0;
      end else begin
         if (start_i && !busy_o) wr_seen <= write_i;
         if (!busy_o || done_o) run_len <= '0;
         else run_len <= run_len + 4'd1;
      end
   end

   // R6: an accepted start raises busy on the next clock
   a_r6_start_busy : assert property (@(posedge clk_i) disable iff (!rst_ni)
      start_i && !busy_o |=> busy_o);
   // R6: busy only falls after a done clock
   a_r6_busy_holds : assert property (@(posedge clk_i) disable iff (!rst_ni)
      busy_o && !done_o |=> busy_o);
   // R6: tick strobes cover exactly the busy clocks
   a_r6_tick_busy : assert property (@(posedge clk_i) disable iff (!rst_ni)
      tick_o |-> busy_o);
   // R6: access lengths are 3, 4 or 6 clocks
   a_r6_len_legal : assert property (@(posedge clk_i) disable iff (!rst_ni)
      done_o |-> (run_len == 4'd2 || run_len == 4'd3 || run_len == 4'd5));
   // R7: a read samples two clocks before done
   a_r7_read_sample : assert property (@(posedge clk_i) disable iff (!rst_ni)
      busy_o && !wr_seen && sample_o |=> busy_o && !done_o ##1 done_o);
   // R8: a write samples exactly on its done clock
   a_r8_write_sample : assert property (@(posedge clk_i) disable iff (!rst_ni)
      busy_o && wr_seen |-> (sample_o == done_o));
   // R9: done is a single-clock strobe inside the access
   a_r9_done_single : assert property (@(posedge clk_i) disable iff (!rst_ni)
      done_o |=> !done_o);
   a_r9_done_in_busy : assert property (@(posedge clk_i) disable iff (!rst_ni)
      done_o |-> busy_o);
   // R11: outputs quiet right after reset
   a_r11_reset_quiet : assert property (@(posedge clk_i)
      !rst_ni |=> !busy_o && !done_o && !sample_o && !tick_o);
endmodule

bind bus_access_timer bus_access_timer_chk u_chk (
   .clk_i    (clk_i),
   .rst_ni   (rst_ni),
   .start_i  (start_i),
   .write_i  (write_i),
   .busy_o   (busy_o),
   .sample_o (sample_o),
   .done_o   (done_o),
   .tick_o   (tick_o)
);

// File: tb/bus_access_timer_tb.sv
module bus_access_timer_tb;
   logic        clk_i = 1'b0;
   logic        rst_ni = 1'b0;
   logic        start_i = 1'b0;
   logic        write_i = 1'b0;
   logic        fast_en_i = 1'b0;
   logic [15:0] addr_i = '0;
   logic        busy_o, sample_o, done_o, tick_o;

   int checks = 0;
   int errors = 0;
   int cycles = 0;
   bit finished = 1'b0;

   always #10 clk_i = ~clk_i;   // 50 MHz

   bus_access_timer u_dut (
      .clk_i     (clk_i),
      .rst_ni    (rst_ni),
      .start_i   (start_i),
      .write_i   (write_i),
      .fast_en_i (fast_en_i),
      .addr_i    (addr_i),
      .busy_o    (busy_o),
      .sample_o  (sample_o),
      .done_o    (done_o),
      .tick_o    (tick_o)
   );

   task automatic chk(input bit ok, input string tag, input int act, input int exp);
      checks++;
      if (!ok) begin
         errors++;
         $display("FAIL %s: actual=%0d expected=%0d (t=%0t)", tag, act, exp, $time);
      end
   endtask

   // Master cycles an access takes, from the address map requirements
   function automatic int exp_mclk(input int bank, input int page, input bit fast);
      if (bank >= 8'h40 && bank <= 8'h7F) return 8;                 // R1
      if (bank >= 8'hC0) return fast ? 6 : 8;                       // R2
      if (page <= 8'h1F || (page >= 8'h60 && page <= 8'h7F)) return 8; // R3
      if (page == 8'h40 || page == 8'h41) return 12;                // R4
      if (page <= 8'h5F) return 6;                                  // R3
      if (bank <= 8'h3F) return 8;                                  // R5
      return fast ? 6 : 8;                                          // R5
   endfunction

   task automatic run_access(input int bank, input int page, input bit wr,
                             input bit fast, input bit disturb, input string tag);
      int n, samp;
      n = exp_mclk(bank, page, fast) / 2;
      samp = wr ? n : n - 2;
      @(negedge clk_i);
      addr_i = 16'((bank << 8) | page);
      write_i = wr;
      fast_en_i = fast;
      start_i = 1'b1;
      @(negedge clk_i);
      start_i = disturb;
      if (disturb) begin
         // R10: new request and changed inputs while busy
         addr_i = 16'h0040;
         write_i = ~wr;
         fast_en_i = ~fast;
      end
      for (int k = 1; k <= n; k++) begin
         chk(busy_o == 1'b1, "R6 busy", int'(busy_o), 1);
         chk(tick_o == 1'b1, "R6 tick", int'(tick_o), 1);
         chk(done_o == (k == n), {tag, " R9 done"}, int'(done_o), int'(k == n));
         chk(sample_o == (k == samp), wr ? "R8 write sample" : "R7 read sample",
             int'(sample_o), int'(k == samp));
         if (disturb) fast_en_i = ~fast_en_i;
         @(negedge clk_i);
      end
      start_i = 1'b0;
      chk(busy_o == 1'b0, disturb ? "R10 ignored start" : {tag, " R6 end"}, int'(busy_o), 0);
      chk(tick_o == 1'b0 && done_o == 1'b0, "R9 quiet after end",
          int'(tick_o) + int'(done_o), 0);
   endtask

   always @(posedge clk_i) begin
      cycles++;
      if (cycles > 150000 && !finished) begin
         finished = 1'b1;
         errors++;
         checks++;
         $display("FAIL watchdog: actual=%0d expected=%0d", cycles, 150000);
         $display("Result: errors=%0d of %0d checks", errors, checks);
         $finish;
      end
   end

   initial begin
      void'($urandom(32'd20231));
      // R11: start held high through reset
      start_i = 1'b1;
      addr_i = 16'h0040;
      repeat (3) @(negedge clk_i);
      chk(!busy_o && !tick_o && !sample_o && !done_o, "R11 in reset",
          int'({busy_o, tick_o, sample_o, done_o}), 0);
      start_i = 1'b0;
      rst_ni = 1'b1;
      @(negedge clk_i);
      chk(!busy_o && !tick_o && !sample_o && !done_o, "R11 after reset",
          int'({busy_o, tick_o, sample_o, done_o}), 0);

      // Directed corners of the map
      run_access(8'h40, 8'h00, 0, 1, 0, "R1");
      run_access(8'h7F, 8'hFF, 1, 1, 0, "R1");
      run_access(8'hC0, 8'h00, 0, 1, 0, "R2");
      run_access(8'hFF, 8'hFF, 0, 0, 0, "R2");
      run_access(8'hC0, 8'h40, 1, 1, 0, "R2");
      run_access(8'h00, 8'h1F, 0, 1, 0, "R3");
      run_access(8'h00, 8'h20, 0, 0, 0, "R3");
      run_access(8'h3F, 8'h3F, 1, 0, 0, "R3");
      run_access(8'hBF, 8'h42, 0, 0, 0, "R3");
      run_access(8'h00, 8'h5F, 0, 0, 0, "R3");
      run_access(8'h00, 8'h60, 1, 1, 0, "R3");
      run_access(8'h80, 8'h7F, 0, 1, 0, "R3");
      run_access(8'h80, 8'h40, 0, 0, 0, "R4");
      run_access(8'h00, 8'h41, 1, 1, 0, "R4");
      run_access(8'h3F, 8'h80, 0, 1, 0, "R5");
      run_access(8'h80, 8'h80, 0, 1, 0, "R5");
      run_access(8'hBF, 8'hFF, 1, 0, 0, "R5");
      run_access(8'h80, 8'hFF, 1, 1, 0, "R5");
      run_access(8'hC0, 8'h00, 0, 1, 1, "R10");
      run_access(8'h10, 8'h30, 1, 0, 1, "R10");

      // Constrained random mix
      for (int i = 0; i < 400; i++) begin
         run_access(int'($urandom_range(0, 255)), int'($urandom_range(0, 255)),
                    1'($urandom_range(0, 1)), 1'($urandom_range(0, 1)),
                    ($urandom_range(0, 3) == 0), "R6 random");
      end

      finished = 1'b1;
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
   end
endmodule